// File: doc/BRIEF.md
# Reloading Countdown Interval Timer

This block is a programmable interval timer for a register-mapped peripheral. Software writes a reload value into two byte-wide base registers, one upper and one lower. A prescaler divides the selected master clock down to a tick of roughly 10 µs. The divisor depends on the clock select: 245 for the first master clock and 168 for the second. A down-counter steps once per tick. At each terminal count it reloads itself from the base registers and, when interrupts are enabled, sets a sticky interrupt flag that stays up until software clears it.

Both master clocks are modelled as a single clock domain (`clk`), and the clock select only chooses the divisor. A write to the lower base byte commits both base bytes into the counter at once, so software writes the upper byte first. A control state machine has two states. `ST_HOLD` freezes the counter and the prescaler. `ST_RUN` lets them advance. Transition GO (`ST_HOLD`→`ST_RUN`) fires when `tmr_en` is sampled high. Transition PAUSE (`ST_RUN`→`ST_HOLD`) fires when `tmr_en` is sampled low. Every other case keeps the current state.

Top module: `interval_timer`

## Requirements
- R1: A write with `wr_addr`=0 stores the lower base byte. In the same edge it loads the counter with {upper base, written byte} and restarts the prescaler from zero. A write with `wr_addr`=1 stores the upper base byte.
- R2: A write to the upper base byte alone leaves the running count untouched. The new upper byte takes effect at the next automatic reload.
- R3: With `clk_sel`=0 a tick occurs every DIV_SEL0 cycles (default 245). With `clk_sel`=1 a tick occurs every DIV_SEL1 cycles (default 168).
- R4: Any change of `clk_sel` restarts the prescaler from zero. No tick is issued in that cycle.
- R5: With a base value N, a terminal-count event occurs every N ticks. At that event the counter reloads from the current base registers. A base of 0 gives a period of 2^(2·BYTE_W) ticks.
- R6: A terminal-count event sets `irq` only while `irq_en` is 1. Events while `irq_en` is 0 leave `irq` low.
- R7: `irq` is sticky and is cleared by a one-cycle `irq_clr`. When a clear and a new event fall in the same cycle, `irq` stays set.
- R8: The state machine registers `tmr_en`. While in `ST_HOLD`, the counter and the prescaler keep their values, so a hold of K cycles lengthens the current interval by exactly K cycles. A lower-byte load still takes effect while held.
- R9: After reset both base bytes and the counter are 0, `irq` is 0 and the state is `ST_HOLD`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (stands for both selectable master clocks) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = lower base byte (and load), 1 = upper base byte |
| wr_data | input | BYTE_W | Write data |
| clk_sel | input | 1 | Master clock select: 0 uses DIV_SEL0, 1 uses DIV_SEL1 |
| tmr_en | input | 1 | Timer run enable |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clear pulse for the interrupt flag |
| irq | output | 1 | Sticky interrupt flag |

## Verification
Two cases are the hardest to reach from the ports.

The first is a clear pulse that lands on the same edge as a terminal-count event. It is reached by loading a known base with the prescaler freshly restarted and leaving the flag set. The bench counts cycles up to the predicted event edge and places `irq_clr` exactly on it.

The second is a change of `clk_sel` partway through a prescale interval. It is reached by loading a base of 1 and flipping the select a fixed number of cycles later. The first event must then arrive one full new divisor after the flip.

Random bases and selects are mixed with these cases. Each interval between flags is measured against a period computed in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_SEL0 = 245,
    parameter int DIV_SEL1 = 168
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int DMAX = (DIV_SEL0 > DIV_SEL1) ? DIV_SEL0 : DIV_SEL1;
    localparam int PW   = (DMAX < 2) ? 1 : $clog2(DMAX);
    localparam logic [PW-1:0] LIM0 = PW'(DIV_SEL0 - 1);
    localparam logic [PW-1:0] LIM1 = PW'(DIV_SEL1 - 1);

    logic [PW-1:0] pre;
    logic [PW-1:0] lim;
    logic          sel_q;
    logic          sel_chg;

    assign lim     = sel ? LIM1 : LIM0;
    assign sel_chg = sel ^ sel_q;
    // a select change or a load starts a fresh prescale interval (R4, R1)
    assign tick    = run && !restart && !sel_chg && (pre == lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre   <= '0;
            sel_q <= 1'b0;
        end else begin
            sel_q <= sel;
            if (restart || sel_chg) begin
                pre <= '0;
            end else if (run) begin
                pre <= (pre == lim) ? '0 : pre + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    // terminal count: the tick that would take the count to zero (R5)
    assign expire = tick && !load && (count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (expire) begin
            count <= reload_val;
        end else if (tick) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int DIV_SEL0 = 245,
    parameter int DIV_SEL1 = 168
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clk_sel,
    input  logic              tmr_en,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              irq
);
    localparam int CNT_W = 2 * BYTE_W;

    tmr_state_t        state;
    tmr_state_t        state_nxt;
    logic              run;
    logic [BYTE_W-1:0] base_hi;
    logic [BYTE_W-1:0] base_lo;
    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  reload_val;
    logic              tick;
    logic              expire;
    logic [CNT_W-1:0]  count;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nxt;
    end

    // next state: GO and PAUSE
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD: if (tmr_en)  state_nxt = ST_RUN;
            ST_RUN:  if (!tmr_en) state_nxt = ST_HOLD;
            default: state_nxt = ST_HOLD;
        endcase
    end

    // state outputs
    always_comb begin
        unique case (state)
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    // base registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            base_lo <= '0;
        end else if (wr_en) begin
            if (wr_addr) base_hi <= wr_data;
            else         base_lo <= wr_data;
        end
    end

    assign load       = wr_en && !wr_addr;
    assign load_val   = {base_hi, wr_data};
    assign reload_val = {base_hi, base_lo};

    tmr_prescale #(
        .DIV_SEL0 (DIV_SEL0),
        .DIV_SEL1 (DIV_SEL1)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (clk_sel),
        .run     (run),
        .restart (load),
        .tick    (tick)
    );

    tmr_downcount #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (load_val),
        .reload_val (reload_val),
        .tick       (tick),
        .count      (count),
        .expire     (expire)
    );

    // sticky flag: a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                irq <= 1'b0;
        else if (expire && irq_en) irq <= 1'b1;
        else if (irq_clr)          irq <= 1'b0;
    end
endmodule

// File: rtl/tmr_checks.sv
module tmr_checks #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                wr_addr,
    input logic [BYTE_W-1:0]   wr_data,
    input logic                clk_sel,
    input logic                irq_en,
    input logic                irq_clr,
    input logic                irq,
    input logic                run,
    input logic                tick,
    input logic                expire,
    input logic [2*BYTE_W-1:0] count,
    input logic [BYTE_W-1:0]   base_hi,
    input logic [BYTE_W-1:0]   base_lo
);
    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> count == {$past(base_hi), $past(wr_data)});

    assert_upper_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && !tick) |=> $stable(count));

    assert_sel_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != $past(clk_sel)) |-> !tick);

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> count == $past({base_hi, base_lo}));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_en && !wr_addr) && count != 1) |=> count == $past(count) - 1'b1);

    assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && irq_en) |=> irq);

    assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !irq) |=> !irq);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(expire && irq_en)) |=> !irq);

    assert_tick_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && !wr_addr)) |=> $stable(count));
endmodule

bind interval_timer tmr_checks #(.BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .clk_sel (clk_sel),
    .irq_en  (irq_en),
    .irq_clr (irq_clr),
    .irq     (irq),
    .run     (run),
    .tick    (tick),
    .expire  (expire),
    .count   (count),
    .base_hi (base_hi),
    .base_lo (base_lo)
);

// File: tb/interval_timer_test.sv
`timescale 1ns/1ps
module interval_timer_test;
    localparam int BW = 4;
    localparam int DA = 5;
    localparam int DB = 3;
    localparam int FULL = 1 << (2 * BW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [BW-1:0] wr_data = '0;
    logic          clk_sel = 1'b0;
    logic          tmr_en = 1'b0;
    logic          irq_en = 1'b1;
    logic          irq_clr = 1'b0;
    logic          irq;

    int cyc = 0;
    int total = 0;
    int bad = 0;

    interval_timer #(.BYTE_W(BW), .DIV_SEL0(DA), .DIV_SEL1(DB)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clk_sel(clk_sel), .tmr_en(tmr_en),
        .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int period(int n, bit s);
        return ((n == 0) ? FULL : n) * (s ? DB : DA);
    endfunction

    task automatic check(int act, int exp, string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(bit a, int d);
        @(negedge clk);
        wr_addr = a; wr_data = BW'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // upper then lower; flag cleared on the load edge; tl = load edge count
    task automatic load(int n, output int tl);
        @(negedge clk);
        wr_addr = 1'b1; wr_data = BW'(n >> BW); wr_en = 1'b1;
        @(negedge clk);
        wr_addr = 1'b0; wr_data = BW'(n); irq_clr = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; irq_clr = 1'b0;
        tl = cyc;
    endtask

    task automatic wait_irq(output int t, input bit do_clr);
        do @(negedge clk); while (!irq);
        t = cyc;
        if (do_clr) begin
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
        end
    endtask

    initial begin
        #(150000 * 5);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t0, t1, t2, t3, tl;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: held after reset, no flag
        repeat (20) @(negedge clk);
        check(int'(irq), 0, "R9 reset irq");

        // R9/R5: reset base 0 -> full period
        tmr_en = 1'b1;
        wait_irq(t0, 1'b1);
        wait_irq(t1, 1'b1);
        check(t1 - t0, period(0, 0), "R9 R5 zero base period");

        // R1/R5: load and auto reload
        load(8'h23, tl);
        wait_irq(t0, 1'b1);
        check(t0 - tl, period(8'h23, 0), "R1 load first interval");
        wait_irq(t1, 1'b1);
        check(t1 - t0, period(8'h23, 0), "R5 reload interval");

        // R5: base 1
        load(1, tl);
        wait_irq(t0, 1'b1);
        wait_irq(t1, 1'b1);
        check(t1 - t0, period(1, 0), "R5 base one");

        // R2: upper write alone
        load(4, tl);
        wait_irq(t1, 1'b1);
        wr(1'b1, 1);
        wait_irq(t2, 1'b1);
        check(t2 - t1, period(4, 0), "R2 running count kept");
        wait_irq(t3, 1'b1);
        check(t3 - t2, period(8'h14, 0), "R2 new upper at reload");

        // R3: select 1
        @(negedge clk); clk_sel = 1'b1;
        load(8'h23, tl);
        wait_irq(t0, 1'b1);
        check(t0 - tl, period(8'h23, 1), "R3 sel1 interval");
        wait_irq(t1, 1'b1);
        check(t1 - t0, period(8'h23, 1), "R3 sel1 reload");

        // R4: select change mid prescale
        @(negedge clk); clk_sel = 1'b0;
        load(1, tl);
        @(negedge clk);
        @(negedge clk); clk_sel = 1'b1;
        wait_irq(t0, 1'b1);
        check(t0 - tl, 3 + DB, "R4 prescaler restart");
        @(negedge clk); clk_sel = 1'b0;

        // R8: hold lengthens the interval by K
        load(8, tl);
        wait_irq(t1, 1'b1);
        tmr_en = 1'b0;
        repeat (7) @(negedge clk);
        tmr_en = 1'b1;
        wait_irq(t2, 1'b1);
        check(t2 - t1, period(8, 0) + 7, "R8 hold adds cycles");

        // R8: load while held
        @(negedge clk); tmr_en = 1'b0;
        repeat (2) @(negedge clk);
        load(2, tl);
        repeat (30) @(negedge clk);
        check(int'(irq), 0, "R8 no event while held");
        tmr_en = 1'b1; t0 = cyc;
        wait_irq(t1, 1'b1);
        check(t1 - t0, 1 + period(2, 0), "R8 load while held");

        // R6: masked events
        irq_en = 1'b0;
        load(2, tl);
        while (cyc < tl + 35) begin
            @(negedge clk);
            if (irq) break;
        end
        check(int'(irq), 0, "R6 masked events");
        irq_en = 1'b1;
        wait_irq(t1, 1'b1);
        check(t1 - tl, 4 * period(2, 0), "R6 enabled event");

        // R7: clear coinciding with event
        load(4, tl);
        wait_irq(t0, 1'b0);
        while (cyc < t0 + period(4, 0) - 1) @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check(int'(irq), 1, "R7 set beats clear");
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check(int'(irq), 0, "R7 clear alone");

        // random bases and selects (R3 R5)
        for (int i = 0; i < 6; i++) begin
            int n;
            bit s;
            n = int'($urandom_range(255, 0));
            s = bit'($urandom_range(1, 0));
            @(negedge clk); clk_sel = s;
            load(n, tl);
            wait_irq(t0, 1'b1);
            check(t0 - tl, period(n, s), "R3 random first");
            wait_irq(t1, 1'b1);
            check(t1 - t0, period(n, s), "R5 random reload");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule